// File: doc/BRIEF.md
# One-Time-Programmable Memory Byte Programming Sequencer

This controller writes a byte-wide one-time-programmable memory over a contiguous address range, one address after another. For every byte it presents the address and the byte taken from a data source port. It then lowers the chip-enable strobe for one base programming interval and reads the cell back through the read strobe. It repeats this until the byte reads correctly or the pulse budget is exhausted. A byte that verifies receives one extra over-programming pulse, three base intervals long for every pulse already spent on it, and is checked once more before the sequencer moves to the next address.

Once the last byte of the range is written, the sequencer drops its programming-voltage select output. It then reads the whole range a second time and compares each location with the source data. The run ends with `done` raised. If any byte exhausts its pulses, or fails the check after its over-programming pulse, or fails the final pass, `error` is also raised and `err_addr` holds the offending address. The analog supply itself is outside the block; only the select level is driven.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset `done`, `error` and `vpp_high` are 0, and `mem_ce_n` and `mem_oe_n` are 1.
- R2: Each base programming pulse holds `mem_ce_n` low for exactly CLK_HZ/1000 clock cycles, and `mem_addr` and `mem_wdata` stay stable while it is low.
- R3: Every programming pulse is followed by a read-back with `mem_oe_n` low before any further pulse. A mismatching read-back is followed by another base pulse.
- R4: A byte receives at most 25 base pulses. If the read-back after the 25th pulse still mismatches, the run ends with `error`=1 and `err_addr` set to that address, and no over-programming pulse is issued.
- R5: A byte that first matches after n base pulses receives exactly one further pulse, `mem_ce_n` low for 3*n*CLK_HZ/1000 cycles.
- R6: After the over-programming pulse the byte is read again. A match moves on to the next address; a mismatch ends the run with `error`=1 at that address.
- R7: After the last address of the write phase, every address from `first_addr` to `last_addr` is read once with `vpp_high`=0. The first mismatch ends the run with `error`=1 and `err_addr` set to that address.
- R8: `vpp_high` is 1 from the start until the write phase ends and 0 otherwise. No pulse occurs while it is 0. `done` rises only at the end of a run, stays high while idle, and is cleared together with `error` by the next `start`.
- R9: `mem_ce_n` and `mem_oe_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| first_addr | input | AW | First address of the range |
| last_addr | input | AW | Last address of the range (not below first_addr) |
| done | output | 1 | Run finished (success or error) |
| error | output | 1 | Run ended on a failing byte |
| err_addr | output | AW | Address of the failing byte |
| src_addr | output | AW | Address for which source data is requested |
| src_data | input | DW | Source byte for src_addr |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory data to program |
| mem_rdata | input | DW | Memory read data |
| mem_ce_n | output | 1 | Programming strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| vpp_high | output | 1 | Programming voltage select |

## Verification
The hardest situations to reach are the 25-pulse exhaustion edge and a byte that passes while the programming voltage is high but fails in the final pass. Neither can occur with a memory that simply stores what is written. The bench therefore models each cell with its own number of pulses needed before it holds its data, and directed runs place cells needing exactly 25 and 26 pulses. A marginal-cell flag makes the model return a corrupted byte only while `vpp_high` is low. Random runs mix these cell kinds across ranges, and the model measures every strobe width as it happens.

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int AW         = 14,
  parameter int DW         = 8,
  parameter int MAX_PULSES = 25,
  parameter int OVER_MULT  = 3,
  parameter int RD_TICKS   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] err_addr,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          vpp_high
);

  localparam int MS_TICKS = CLK_HZ / 1000;
  localparam int TW = $clog2(OVER_MULT * MAX_PULSES * MS_TICKS + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_RDSET, S_READ} st_t;

  st_t           st;
  logic [AW-1:0] addr;
  logic [PW-1:0] pc;
  logic          ovr, fin;
  logic [TW-1:0] tmr;

  logic          match, at_last;
  logic [TW-1:0] over_len;

  assign match    = (mem_rdata == src_data);
  assign at_last  = (addr == last_addr);
  assign over_len = TW'(pc) * TW'(OVER_MULT * MS_TICKS);

  assign src_addr  = addr;
  assign mem_addr  = addr;
  assign mem_wdata = src_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr     <= '0;
      pc       <= '0;
      ovr      <= 1'b0;
      fin      <= 1'b0;
      tmr      <= '0;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      vpp_high <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      err_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr     <= first_addr;
          pc       <= '0;
          ovr      <= 1'b0;
          fin      <= 1'b0;
          vpp_high <= 1'b1;
          done     <= 1'b0;
          error    <= 1'b0;
          err_addr <= '0;
          st       <= S_SETUP;
        end
        S_SETUP: begin
          mem_ce_n <= 1'b0;
          if (ovr) tmr <= over_len - TW'(1);
          else begin
            tmr <= TW'(MS_TICKS - 1);
            pc  <= pc + PW'(1);
          end
          st <= S_PULSE;
        end
        S_PULSE: begin
          if (tmr == '0) begin
            mem_ce_n <= 1'b1;
            st       <= S_RDSET;
          end else tmr <= tmr - TW'(1);
        end
        S_RDSET: begin
          mem_oe_n <= 1'b0;
          tmr      <= TW'(RD_TICKS - 1);
          st       <= S_READ;
        end
        S_READ: begin
          if (tmr != '0) tmr <= tmr - TW'(1);
          else begin
            mem_oe_n <= 1'b1;
            if ((fin || ovr) && !match || !fin && !ovr && !match && pc == PW'(MAX_PULSES)) begin
              error    <= 1'b1;
              err_addr <= addr;
              done     <= 1'b1;
              vpp_high <= 1'b0;
              st       <= S_IDLE;
            end else if (fin) begin
              if (at_last) begin
                done <= 1'b1;
                st   <= S_IDLE;
              end else begin
                addr <= addr + AW'(1);
                st   <= S_RDSET;
              end
            end else if (!ovr) begin
              if (match) ovr <= 1'b1;
              st <= S_SETUP;
            end else if (at_last) begin
              fin      <= 1'b1;
              vpp_high <= 1'b0;
              addr     <= first_addr;
              st       <= S_RDSET;
            end else begin
              addr <= addr + AW'(1);
              pc   <= '0;
              ovr  <= 1'b0;
              st   <= S_SETUP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_ce_n && !mem_oe_n)); // R9
  AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$rose(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R2
  AST_PULSE_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> vpp_high); // R8
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= PW'(MAX_PULSES)); // R4
  AST_READ_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> !mem_oe_n); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_ce_n && mem_oe_n && !vpp_high)); // R8

endmodule

// File: tb/otp_prog_seq_bench.sv
module otp_prog_seq_bench;
  localparam int AW = 14, DW = 8, CLK_HZ = 4000, MS = CLK_HZ / 1000, NC = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic done, error, mem_ce_n, mem_oe_n, vpp_high;
  logic [AW-1:0] err_addr, src_addr, mem_addr;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  otp_prog_seq #(.CLK_HZ(CLK_HZ), .AW(AW), .DW(DW)) u_otp_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr), .last_addr(last_addr),
    .done(done), .error(error), .err_addr(err_addr), .src_addr(src_addr), .src_data(src_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .vpp_high(vpp_high));

  function automatic logic [DW-1:0] data_fn(input logic [AW-1:0] a);
    return DW'(a * 37 + 5) ^ 8'h5A;
  endfunction
  assign src_data = data_fn(src_addr);

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int need [NC];
  bit marg [NC];
  int cnt [NC], ovc [NC];
  int wid = 0, final_reads = 0;
  bit prev_ce = 1'b1, prev_oe = 1'b1, clr = 1'b0;
  logic [DW-1:0] rd_q = '0;
  assign mem_rdata = rd_q;

  always @(negedge clk) begin
    int a;
    a = int'(mem_addr[3:0]);
    if (clr) begin
      for (int i = 0; i < NC; i++) begin cnt[i] = 0; ovc[i] = 0; end
      final_reads = 0;
      wid = 0;
    end else begin
      if (!mem_ce_n) wid++;
      if (mem_ce_n && !prev_ce) begin
        if (cnt[a] >= need[a]) begin
          chk(wid == 3 * cnt[a] * MS, "R5 over pulse width", wid, 3 * cnt[a] * MS);
          ovc[a]++;
        end else begin
          chk(wid == MS, "R2 base pulse width", wid, MS);
          cnt[a]++;
        end
        wid = 0;
      end
      if (!mem_oe_n && prev_oe && !vpp_high) final_reads++;
    end
    prev_ce = mem_ce_n;
    prev_oe = mem_oe_n;
    if (cnt[a] >= need[a]) rd_q = (marg[a] && !vpp_high) ? (data_fn(mem_addr) ^ 8'h01) : data_fn(mem_addr);
    else rd_q = ~data_fn(mem_addr);
  end

  task automatic run(input int f, input int l);
    int exp_err, exp_ea, exp_fr, cyc, lim;
    exp_err = 0; exp_ea = 0; exp_fr = 0;
    for (int a = f; a <= l; a++)
      if (!exp_err && need[a] > 25) begin exp_err = 1; exp_ea = a; end
    if (!exp_err) begin
      exp_fr = l - f + 1;
      for (int a = f; a <= l; a++)
        if (!exp_err && marg[a]) begin exp_err = 1; exp_ea = a; exp_fr = a - f + 1; end
    end
    lim = exp_err && exp_fr == 0 ? exp_ea : l;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    first_addr = AW'(f); last_addr = AW'(l); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(!done && !error, "R8 start clears done/error", {done, error}, 0);
    chk(vpp_high, "R8 vpp high in write phase", vpp_high, 1);
    cyc = 0;
    while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
    chk(done, "R8 run completes (watchdog)", done, 1);
    if (!done) begin
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; return;
    end
    chk(error == exp_err, exp_fr == 0 ? "R4 error flag" : "R7 error flag", error, exp_err);
    if (exp_err) chk(int'(err_addr) == exp_ea, exp_fr == 0 ? "R4 err_addr" : "R7 err_addr", err_addr, exp_ea);
    chk(!vpp_high, "R8 vpp low after run", vpp_high, 0);
    chk(final_reads == exp_fr, "R7 final pass read count", final_reads, exp_fr);
    for (int a = f; a <= lim; a++) begin
      int en, eo;
      en = need[a] > 25 ? 25 : need[a];
      eo = need[a] > 25 ? 0 : 1;
      chk(cnt[a] == en, "R3 base pulses per byte", cnt[a], en);
      chk(ovc[a] == eo, "R6 over pulses per byte", ovc[a], eo);
    end
    repeat (3) @(negedge clk);
    chk(done, "R8 done held while idle", done, 1);
  endtask

  task automatic clear_cells();
    for (int i = 0; i < NC; i++) begin need[i] = 1; marg[i] = 1'b0; end
  endtask

  initial begin
    void'($urandom(32'd1234));
    clear_cells();
    repeat (2) @(negedge clk);
    chk(!done && !error && !vpp_high && mem_ce_n && mem_oe_n, "R1 reset state",
        {done, error, vpp_high, mem_ce_n, mem_oe_n}, 3);
    rst_n = 1'b1;
    run(0, 3);
    clear_cells(); need[5] = 7; run(5, 5);
    clear_cells(); need[2] = 25; need[1] = 4; run(0, 4);
    clear_cells(); need[3] = 26; need[1] = 2; run(0, 6);
    clear_cells(); need[4] = 3; marg[6] = 1'b1; run(2, 9);
    for (int r = 0; r < 6; r++) begin
      int f, l;
      clear_cells();
      for (int i = 0; i < NC; i++) begin
        need[i] = $urandom_range(1, 8);
        if ($urandom_range(0, 11) == 0) need[i] = 26;
        marg[i] = ($urandom_range(0, 9) == 0);
      end
      f = $urandom_range(0, 7);
      l = f + $urandom_range(0, 8);
      run(f, l);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5000000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule